// File: doc/BRIEF.md
# Two-Colour LED Phase Sequencer

This block lights a red LED and a green LED according to a repeating four-stage cycle. Each LED has a four-bit on/off mask, one bit per stage. Both masks share one 8-bit pattern byte. A free-running timer holds each stage for a fixed number of clock cycles and steps through stages 0, 1, 2, 3, then back to 0.

Software loads the pattern through a small write port that carries a register number and a data byte. Writing register 8 stages a pattern without changing the LEDs. Writing the value 1 to register 7 arms that staged pattern. The LEDs switch to it at the next return to stage 0, so a single cycle never shows parts of two patterns.

Top module: `led_phase_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first commit takes effect, red_o and green_o are both 0. The active pattern resets to 8'h00 and the stage counter resets to stage 0.
- R2: Each stage lasts exactly STAGE_CYCLES clock cycles. The stage counter advances 0, 1, 2, 3 and then wraps to 0. After the k-th rising edge following reset release, the stage is (k / STAGE_CYCLES) mod 4.
- R3: In stage s, red_o equals bit (7 - s) of the active pattern. Bit 7 is stage 0 and bit 4 is stage 3.
- R4: In stage s, green_o equals bit (3 - s) of the active pattern. Bit 3 is stage 0 and bit 0 is stage 3.
- R5: A write to register 8 stores wr_data_i as the staged pattern and does not change either LED output.
- R6: A write of 8'h01 to register 7 captures the staged pattern as pending. The pending pattern becomes active on the edge that ends stage 3, and stays pending until then.
- R7: A write to register 7 with any value other than 8'h01 has no effect.
- R8: Writes to any register number other than 7 and 8 have no effect on the staged, pending or active pattern.
- R9: A write to register 8 made after a commit does not alter the pattern already pending. A second commit before the boundary replaces the pending pattern with the staged pattern at that time.
- R10: Both LEDs may be lit in the same stage when both of that stage's bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Register number of the write |
| wr_data_i | input | 8 | Write data |
| red_o | output | 1 | Red LED on |
| green_o | output | 1 | Green LED on |

## Verification
The assertions assume that the write strobe, address and data are stable around the rising edge. They also assume that at most one register is written per cycle, which the single-port interface enforces. The bench drives every input on the falling edge and holds the strobe for exactly one cycle per write. The bench issues commits at arbitrary offsets within the cycle, including close to the stage-3 boundary. This exercises the pending-pattern handover without relying on any particular alignment between writes and stages.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  localparam int NUM_STAGES = 4;
  localparam int STAGE_W    = 2;
  localparam int PAT_W      = 8;
  localparam int NUM_LEDS   = PAT_W / NUM_STAGES;
  localparam int REG_PAT    = 8;
  localparam int REG_COMMIT = 7;
  localparam int COMMIT_VAL = 1;

  typedef logic [STAGE_W-1:0] stage_t;
  typedef logic [PAT_W-1:0]   pat_t;
endpackage

// File: rtl/led_seq_timer.sv
module led_seq_timer
  import led_seq_pkg::*;
#(
  parameter int STAGE_CYCLES = 1000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  output stage_t stage_o,
  output logic   wrap_o
);
  localparam int CNT_W = (STAGE_CYCLES > 1) ? $clog2(STAGE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(STAGE_CYCLES - 1);
  localparam stage_t           STAGE_END = STAGE_W'(NUM_STAGES - 1);

  logic [CNT_W-1:0] cnt_q;
  stage_t           stage_q;
  logic             stage_done;

  assign stage_done = (cnt_q == CNT_LAST);
  assign wrap_o     = stage_done && (stage_q == STAGE_END);
  assign stage_o    = stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stage_q <= '0;
    end else if (stage_done) begin
      cnt_q   <= '0;
      stage_q <= stage_q + stage_t'(1);
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  a_r2_stage_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CNT_LAST) |=> $stable(stage_q));
  a_r2_stage_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_LAST && stage_q == STAGE_END) |=> (stage_q == '0));
endmodule

// File: rtl/led_seq_regs.sv
module led_seq_regs
  import led_seq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  pat_t              wr_data_i,
  input  logic              wrap_i,
  output pat_t              active_o
);
  localparam logic [ADDR_W-1:0] ADDR_PAT    = ADDR_W'(REG_PAT);
  localparam logic [ADDR_W-1:0] ADDR_COMMIT = ADDR_W'(REG_COMMIT);

  pat_t staged_q, pend_q, active_q;
  logic pend_vld_q;
  logic pat_wr, commit_wr;

  assign pat_wr    = wr_en_i && (wr_addr_i == ADDR_PAT);
  assign commit_wr = wr_en_i && (wr_addr_i == ADDR_COMMIT) && (wr_data_i == pat_t'(COMMIT_VAL));
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q   <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      active_q   <= '0;
    end else begin
      if (pat_wr) staged_q <= wr_data_i;
      // hand over the armed pattern at the cycle seam; a same-cycle commit re-arms
      if (wrap_i && pend_vld_q) begin
        active_q   <= pend_q;
        pend_vld_q <= 1'b0;
      end
      if (commit_wr) begin
        pend_q     <= staged_q;
        pend_vld_q <= 1'b1;
      end
    end
  end

  a_r6_active_only_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(active_q));
  a_r6_commit_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && pend_vld_q) |=> (active_q == $past(pend_q)));
  a_r5_staged_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_wr |=> $stable(staged_q));
  a_r8_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != ADDR_PAT && wr_addr_i != ADDR_COMMIT)
      |=> ($stable(staged_q) && $stable(pend_q)));
  a_r9_pending_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_wr |=> $stable(pend_q));
endmodule

// File: rtl/led_seq_out.sv
module led_seq_out
  import led_seq_pkg::*;
(
  input  stage_t active_stage_i,
  input  pat_t   pat_i,
  output logic   red_o,
  output logic   green_o
);
  logic [NUM_LEDS-1:0] lit;

  // LED c owns a NUM_STAGES-wide field, stage 0 at its top bit
  for (genvar c = 0; c < NUM_LEDS; c++) begin : g_led
    logic [NUM_STAGES-1:0] field;
    assign field  = pat_i[PAT_W-1-c*NUM_STAGES -: NUM_STAGES];
    assign lit[c] = field[STAGE_W'(NUM_STAGES-1) - active_stage_i];
  end

  assign red_o   = lit[0];
  assign green_o = lit[1];
endmodule

// File: rtl/led_phase_seq.sv
module led_phase_seq
  import led_seq_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int STAGE_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              red_o,
  output logic              green_o
);
  stage_t stage;
  logic   wrap;
  pat_t   active;

  led_seq_timer #(.STAGE_CYCLES(STAGE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stage_o (stage),
    .wrap_o  (wrap)
  );

  led_seq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wrap_i    (wrap),
    .active_o  (active)
  );

  led_seq_out u_out (
    .active_stage_i (stage),
    .pat_i          (active),
    .red_o          (red_o),
    .green_o        (green_o)
  );

  a_r1_dark_until_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active == '0) |-> (!red_o && !green_o));
endmodule

// File: tb/led_phase_seq_tb.sv
module led_phase_seq_tb_top;
  localparam int ADDR_W = 4;
  localparam int L      = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [7:0]       wr_data_i = '0;
  logic             red_o, green_o;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;
  bit mon_en = 0;
  string cur_req = "R1";

  // reference state, built from the requirements
  int   m_k = 0;
  logic [7:0] m_staged = 0, m_pend = 0, m_act = 0;
  logic m_pvld = 0;

  always #2.5 clk_i = ~clk_i;

  led_phase_seq #(.ADDR_W(ADDR_W), .STAGE_CYCLES(L)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .red_o(red_o), .green_o(green_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_k <= 0; m_staged <= 0; m_pend <= 0; m_act <= 0; m_pvld <= 0;
    end else begin
      m_k <= m_k + 1;
      if (((m_k + 1) % (4 * L)) == 0 && m_pvld) begin  // R6 boundary
        m_act <= m_pend; m_pvld <= 0;
      end
      if (wr_en_i && wr_addr_i == 4'd8) m_staged <= wr_data_i;
      if (wr_en_i && wr_addr_i == 4'd7 && wr_data_i == 8'd1) begin
        m_pend <= m_staged; m_pvld <= 1;
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    cycles++;
    if (!rst_ni) begin
      chk("R1 reset red", red_o, 1'b0);
      chk("R1 reset green", green_o, 1'b0);
    end else if (mon_en) begin
      int s;
      s = (m_k / L) % 4;  // R2 stage from edge count
      chk({cur_req, "/R3 red"},   red_o,   m_act[7 - s]);
      chk({cur_req, "/R4 green"}, green_o, m_act[3 - s]);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = ADDR_W'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    idle(4);
    @(negedge clk_i); rst_ni = 1'b1; mon_en = 1;
    cur_req = "R1"; idle(4 * L + 2);
    cur_req = "R2"; idle(8 * L);

    // R5: staging alone leaves LEDs dark; R8: foreign addresses ignored
    cur_req = "R5"; wr(8, 8'hA5); idle(8 * L);
    cur_req = "R8";
    for (int a = 0; a < 16; a++) if (a != 7 && a != 8) wr(a, 8'h01);
    idle(8 * L);
    for (int a = 0; a < 16; a++) if (a != 7 && a != 8) wr(a, 8'h5A);
    wr(7, 1); idle(8 * L);

    // R7: non-one values to the commit register do nothing
    cur_req = "R7"; wr(8, 8'hFF);
    for (int v = 0; v < 256; v += 3) if (v != 1) wr(7, v);
    idle(8 * L);
    wr(7, 1); idle(8 * L);

    // R6: commits at every offset within the cycle
    cur_req = "R6";
    for (int off = 0; off < 4 * L + 1; off++) begin
      wr(8, 8'h80 >> (off % 8)); idle(off); wr(7, 1); idle(3 * L);
    end

    // R9: later staging keeps the armed pattern; re-commit replaces it
    cur_req = "R9";
    wr(8, 8'h0F); wr(7, 1); wr(8, 8'hF0); idle(8 * L);
    wr(8, 8'h33); wr(7, 1); wr(8, 8'hCC); wr(7, 1); idle(8 * L);

    // R10: both lit in one stage
    cur_req = "R10"; wr(8, 8'h22); wr(7, 1); idle(8 * L);
    wr(8, 8'hFF); wr(7, 1); idle(8 * L);

    // R3/R4 exhaustive pattern sweep
    cur_req = "R3R4";
    for (int p = 0; p < 256; p++) begin
      wr(8, p); wr(7, 1); idle(4 * L + (p % 5));
    end
    idle(8 * L);
    finish_up();
  end
endmodule